// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block produces every digital timing waveform that an interline CCD image sensor needs during readout, as plain logic levels. It runs from a master clock that is four times the pixel rate. Each pixel period is divided into four sub-phases. Within one pixel period the block issues the output-node reset pulse, the reset-level sampling strobe, the rising edge of the first horizontal phase and the signal-level sampling strobe, in that order. In every line's horizontal blanking it runs a four-phase vertical shift. During that shift the horizontal drive is held still.

On one chosen line of each frame, the readout pulses move charge from the photodiodes into the vertical registers. These pulses sit inside the high windows of the first and third vertical phases. An electronic shutter sweep pulse is emitted on every line from the start of the frame up to a programmable line. The shutter line is captured at the frame boundary, so that one frame never sees two exposure settings. A synchronous frame-start input restarts the sub-phase, pixel and line counters. The counters and a line-start flag are brought out so that downstream capture logic can align to them.

By default the array is 1077 pixels by 788 lines. All geometry is set by parameters, so smaller arrays can be built for test.

Top module: `ccd_timing_gen`

## Requirements
- R1: The sub-phase count `pix_phase` runs 0,1,2,3 on successive clocks. `pix_cnt` advances when `pix_phase` goes from 3 to 0 and wraps from H_TOTAL-1 to 0. `line_cnt` advances when `pix_cnt` wraps and wraps from V_TOTAL-1 to 0.
- R2: `hclk_a` and `hclk_b` are always complementary. Outside the vertical window, `hclk_a` is 1 exactly in sub-phases 2 and 3.
- R3: Outside the vertical window, `rst_gate` is 1 only in sub-phase 0, `samp_ref` only in sub-phase 1 and `samp_dat` only in sub-phase 3. The rise of `hclk_a` falls between `samp_ref` and `samp_dat`, and at most one of the three pulses is high at a time.
- R4: The vertical window covers pixels VX_START to VX_START+5*VX_STEP-1 and is split into five steps of VX_STEP pixels (step 0 to 4). Bit i of `vclk` (i=0..3) is 1 in steps i and i+1 and is 0 outside the window.
- R5: While the vertical window is active, `hclk_a`=0, `hclk_b`=1 and `rst_gate`, `samp_ref` and `samp_dat` are all 0.
- R6: On line READ_LINE only, `rdout_a` is 1 during step 1 and `rdout_b` is 1 during step 3. On all other lines and at all other times both are 0.
- R7: `sweep` is 1 on pixels XSUB_START to XSUB_START+XSUB_LEN-1 of every line whose number is below the captured shutter line, and is 0 otherwise.
- R8: The captured shutter line takes the value of `shutter_line` only on a clock where `frame_start` is high or where the counters wrap from the last sub-phase of the last line. A change of `shutter_line` at any other time has no effect on `sweep` in the current frame.
- R9: A high `frame_start` at a clock edge sets `pix_phase`, `pix_cnt` and `line_cnt` to 0 at that edge, whatever their previous values.
- R10: `line_start` is 1 exactly when `pix_cnt` is 0 and `pix_phase` is 0.
- R11: While reset is held, and until the first clock after the internal reset release, all counters and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Synchronous restart of all counters; also loads the shutter line |
| shutter_line | input | $clog2(V_TOTAL) | Last line (exclusive) that receives a sweep pulse |
| hclk_a | output | 1 | First horizontal transfer phase |
| hclk_b | output | 1 | Second horizontal transfer phase |
| rst_gate | output | 1 | Output-node reset pulse |
| samp_ref | output | 1 | Reset-level sampling strobe |
| samp_dat | output | 1 | Signal-level sampling strobe |
| vclk | output | 4 | Vertical transfer phases, bit 0 is the first phase |
| rdout_a | output | 1 | Readout pulse within the first vertical phase |
| rdout_b | output | 1 | Readout pulse within the third vertical phase |
| sweep | output | 1 | Electronic shutter charge sweep pulse |
| pix_phase | output | 2 | Sub-phase within the pixel period |
| pix_cnt | output | $clog2(H_TOTAL) | Pixel counter |
| line_cnt | output | $clog2(V_TOTAL) | Line counter |
| line_start | output | 1 | First clock of each line |

## Verification
Every drive output is registered from the next-state value of the counters. Each output therefore changes on the same edge as the counter ports, with no extra delay. The bench keeps its own counter model, updated at the same posedge as the design, and checks all outputs against that model at each negedge. After `rst_n` rises, the synchronizer adds two edges, so the counters first move on the third edge. The shutter line loaded on a `frame_start` edge already governs `sweep` in the cycle that follows that edge. The directed check of the frame restart is taken at the first negedge after the pulse.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;
  localparam int unsigned SUB_N = 4;
  localparam int unsigned SUB_W = 2;
  localparam logic [SUB_W-1:0] SUB_RESET = 2'd0;
  localparam logic [SUB_W-1:0] SUB_REF   = 2'd1;
  localparam logic [SUB_W-1:0] SUB_RISE  = 2'd2;
  localparam logic [SUB_W-1:0] SUB_DAT   = 2'd3;
  localparam int unsigned V_STEPS = 5;

  typedef struct packed {
    logic hclk_a;
    logic hclk_b;
    logic rst_gate;
    logic samp_ref;
    logic samp_dat;
  } hdrv_t;
endpackage

// File: rtl/ccdtg_counters.sv
module ccdtg_counters
  import ccdtg_pkg::*;
#(
  parameter int unsigned H_TOTAL = 1077,
  parameter int unsigned V_TOTAL = 788,
  parameter int unsigned PW      = $clog2(H_TOTAL),
  parameter int unsigned LW      = $clog2(V_TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic [SUB_W-1:0] sub_q,
  output logic [PW-1:0]    pix_q,
  output logic [LW-1:0]    line_q,
  output logic [SUB_W-1:0] sub_d,
  output logic [PW-1:0]    pix_d,
  output logic [LW-1:0]    line_d,
  output logic             wrap_d,
  output logic             line_start_q
);
  localparam logic [PW-1:0] PIX_LAST  = PW'(H_TOTAL - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(V_TOTAL - 1);

  logic last_sub, last_pix, last_line;

  assign last_sub  = (sub_q == SUB_DAT);
  assign last_pix  = (pix_q == PIX_LAST);
  assign last_line = (line_q == LINE_LAST);

  always_comb begin
    sub_d  = sub_q + SUB_W'(1);
    pix_d  = pix_q;
    line_d = line_q;
    wrap_d = 1'b0;
    if (last_sub) begin
      pix_d = last_pix ? '0 : pix_q + PW'(1);
      if (last_pix) begin
        line_d = last_line ? '0 : line_q + LW'(1);
        wrap_d = last_line;
      end
    end
    if (frame_start) begin
      sub_d  = '0;
      pix_d  = '0;
      line_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q        <= '0;
      pix_q        <= '0;
      line_q       <= '0;
      line_start_q <= 1'b0;
    end else begin
      sub_q        <= sub_d;
      pix_q        <= pix_d;
      line_q       <= line_d;
      line_start_q <= (sub_d == SUB_RESET) && (pix_d == '0);
    end
  end

  p_pix_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_q <= PIX_LAST) && (line_q <= LINE_LAST));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sub_q == '0) && (pix_q == '0) && (line_q == '0));

  p_pix_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !last_sub) |=> $stable(pix_q));
endmodule

// File: rtl/ccdtg_hdrive.sv
module ccdtg_hdrive
  import ccdtg_pkg::*;
#(
  parameter int unsigned PW       = 11,
  parameter int unsigned VX_START = 1048,
  parameter int unsigned VX_STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUB_W-1:0] sub_d,
  input  logic [PW-1:0]    pix_d,
  output hdrv_t            drv_q
);
  localparam logic [PW-1:0] VX_LO = PW'(VX_START);
  localparam logic [PW-1:0] VX_HI = PW'(VX_START + V_STEPS * VX_STEP);

  logic  hold_d;
  hdrv_t drv_d;

  assign hold_d = (pix_d >= VX_LO) && (pix_d < VX_HI);

  always_comb begin
    drv_d.hclk_a   = !hold_d && (sub_d >= SUB_RISE);
    drv_d.hclk_b   = hold_d || (sub_d < SUB_RISE);
    drv_d.rst_gate = !hold_d && (sub_d == SUB_RESET);
    drv_d.samp_ref = !hold_d && (sub_d == SUB_REF);
    drv_d.samp_dat = !hold_d && (sub_d == SUB_DAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= '0;
    else        drv_q <= drv_d;
  end

  p_hclk_compl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (drv_q.hclk_a != drv_q.hclk_b));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_q.rst_gate, drv_q.samp_ref, drv_q.samp_dat}));

  p_ref_before_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q.hclk_a) |-> $past(drv_q.samp_ref));

  p_dat_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q.samp_dat) |-> $past(drv_q.hclk_a));
endmodule

// File: rtl/ccdtg_vdrive.sv
module ccdtg_vdrive
  import ccdtg_pkg::*;
#(
  parameter int unsigned PW        = 11,
  parameter int unsigned LW        = 10,
  parameter int unsigned VX_START  = 1048,
  parameter int unsigned VX_STEP   = 4,
  parameter int unsigned READ_LINE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pix_d,
  input  logic [LW-1:0] line_d,
  output logic [3:0]    vclk_q,
  output logic          rdout_a_q,
  output logic          rdout_b_q
);
  localparam logic [PW-1:0] VX_LO  = PW'(VX_START);
  localparam logic [PW-1:0] VX_HI  = PW'(VX_START + V_STEPS * VX_STEP);
  localparam logic [PW-1:0] STEP_P = PW'(VX_STEP);
  localparam logic [LW-1:0] RD_LN  = LW'(READ_LINE);

  logic          win_d, rd_line_d;
  logic [PW-1:0] step_d;
  logic [3:0]    vclk_d;

  assign win_d     = (pix_d >= VX_LO) && (pix_d < VX_HI);
  assign step_d    = (pix_d - VX_LO) / STEP_P;
  assign rd_line_d = (line_d == RD_LN);

  for (genvar i = 0; i < 4; i++) begin : g_phase
    assign vclk_d[i] = win_d && ((step_d == PW'(i)) || (step_d == PW'(i + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vclk_q    <= '0;
      rdout_a_q <= 1'b0;
      rdout_b_q <= 1'b0;
    end else begin
      vclk_q    <= vclk_d;
      rdout_a_q <= win_d && rd_line_d && (step_d == PW'(1));
      rdout_b_q <= win_d && rd_line_d && (step_d == PW'(3));
    end
  end

  p_rdout_a_in_v1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdout_a_q |-> vclk_q[0]);

  p_rdout_b_in_v3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdout_b_q |-> vclk_q[2]);

  p_phase_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vclk_q) <= 2);
endmodule

// File: rtl/ccdtg_shutter.sv
module ccdtg_shutter #(
  parameter int unsigned PW         = 11,
  parameter int unsigned LW         = 10,
  parameter int unsigned XSUB_START = 1040,
  parameter int unsigned XSUB_LEN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          wrap_d,
  input  logic [LW-1:0] shutter_line,
  input  logic [PW-1:0] pix_d,
  input  logic [LW-1:0] line_d,
  output logic          sweep_q
);
  localparam logic [PW-1:0] XS_LO = PW'(XSUB_START);
  localparam logic [PW-1:0] XS_HI = PW'(XSUB_START + XSUB_LEN);

  logic          load_en;
  logic [LW-1:0] shut_q, shut_d;
  logic          sweep_d;

  assign load_en = frame_start || wrap_d;
  assign shut_d  = load_en ? shutter_line : shut_q;
  assign sweep_d = (line_d < shut_d) && (pix_d >= XS_LO) && (pix_d < XS_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q  <= '0;
      sweep_q <= 1'b0;
    end else begin
      if (load_en) shut_q <= shutter_line;
      sweep_q <= sweep_d;
    end
  end

  p_sweep_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_q) |-> (shut_q != '0));
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccdtg_pkg::*;
#(
  parameter int unsigned H_TOTAL    = 1077,
  parameter int unsigned V_TOTAL    = 788,
  parameter int unsigned VX_START   = 1048,
  parameter int unsigned VX_STEP    = 4,
  parameter int unsigned XSUB_START = 1040,
  parameter int unsigned XSUB_LEN   = 4,
  parameter int unsigned READ_LINE  = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic [$clog2(V_TOTAL)-1:0] shutter_line,
  output logic                       hclk_a,
  output logic                       hclk_b,
  output logic                       rst_gate,
  output logic                       samp_ref,
  output logic                       samp_dat,
  output logic [3:0]                 vclk,
  output logic                       rdout_a,
  output logic                       rdout_b,
  output logic                       sweep,
  output logic [1:0]                 pix_phase,
  output logic [$clog2(H_TOTAL)-1:0] pix_cnt,
  output logic [$clog2(V_TOTAL)-1:0] line_cnt,
  output logic                       line_start
);
  localparam int unsigned PW = $clog2(H_TOTAL);
  localparam int unsigned LW = $clog2(V_TOTAL);

  logic             rst_meta, rst_sync;
  logic [SUB_W-1:0] sub_d;
  logic [PW-1:0]    pix_d;
  logic [LW-1:0]    line_d;
  logic             wrap_d;
  hdrv_t            drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ccdtg_counters #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .PW(PW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .frame_start(frame_start),
    .sub_q(pix_phase), .pix_q(pix_cnt), .line_q(line_cnt),
    .sub_d(sub_d), .pix_d(pix_d), .line_d(line_d), .wrap_d(wrap_d),
    .line_start_q(line_start)
  );

  ccdtg_hdrive #(.PW(PW), .VX_START(VX_START), .VX_STEP(VX_STEP)) u_hdrv (
    .clk(clk), .rst_n(rst_sync), .sub_d(sub_d), .pix_d(pix_d), .drv_q(drv)
  );

  ccdtg_vdrive #(.PW(PW), .LW(LW), .VX_START(VX_START), .VX_STEP(VX_STEP),
                 .READ_LINE(READ_LINE)) u_vdrv (
    .clk(clk), .rst_n(rst_sync), .pix_d(pix_d), .line_d(line_d),
    .vclk_q(vclk), .rdout_a_q(rdout_a), .rdout_b_q(rdout_b)
  );

  ccdtg_shutter #(.PW(PW), .LW(LW), .XSUB_START(XSUB_START), .XSUB_LEN(XSUB_LEN)) u_shut (
    .clk(clk), .rst_n(rst_sync), .frame_start(frame_start), .wrap_d(wrap_d),
    .shutter_line(shutter_line), .pix_d(pix_d), .line_d(line_d), .sweep_q(sweep)
  );

  assign hclk_a   = drv.hclk_a;
  assign hclk_b   = drv.hclk_b;
  assign rst_gate = drv.rst_gate;
  assign samp_ref = drv.samp_ref;
  assign samp_dat = drv.samp_dat;

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    (|vclk) |-> (!hclk_a && hclk_b && !rst_gate && !samp_ref && !samp_dat));

  p_line_flag_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    line_start |-> ((pix_cnt == '0) && (pix_phase == 2'd0)));

  p_sweep_apart_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    sweep |-> (vclk == 4'b0000));
endmodule

// File: tb/ccd_timing_gen_bench.sv
module ccd_timing_gen_bench;
  localparam int H = 32;
  localparam int V = 10;
  localparam int VXS = 20;
  localparam int VXP = 2;
  localparam int XS = 14;
  localparam int XL = 3;
  localparam int RL = 3;
  localparam int PW = $clog2(H);
  localparam int LW = $clog2(V);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, frame_start;
  logic [LW-1:0] shutter_line;
  logic hclk_a, hclk_b, rst_gate, samp_ref, samp_dat, rdout_a, rdout_b, sweep, line_start;
  logic [3:0] vclk;
  logic [1:0] pix_phase;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  ccd_timing_gen #(.H_TOTAL(H), .V_TOTAL(V), .VX_START(VXS), .VX_STEP(VXP),
                   .XSUB_START(XS), .XSUB_LEN(XL), .READ_LINE(RL)) u_ccd_timing_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .shutter_line(shutter_line),
    .hclk_a(hclk_a), .hclk_b(hclk_b), .rst_gate(rst_gate), .samp_ref(samp_ref),
    .samp_dat(samp_dat), .vclk(vclk), .rdout_a(rdout_a), .rdout_b(rdout_b),
    .sweep(sweep), .pix_phase(pix_phase), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .line_start(line_start)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Bench model of the counters and captured shutter line
  int m_sub, m_pix, m_line, m_shut, hi_cnt;
  bit m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0; m_sub <= 0; m_pix <= 0; m_line <= 0; m_shut <= 0; m_run <= 0;
    end else begin
      if (hi_cnt < 3) hi_cnt <= hi_cnt + 1;
      if (hi_cnt >= 2) begin
        m_run <= 1;
        if (frame_start || (m_sub == 3 && m_pix == H-1 && m_line == V-1))
          m_shut <= int'(shutter_line);
        if (frame_start) begin
          m_sub <= 0; m_pix <= 0; m_line <= 0;
        end else begin
          m_sub <= (m_sub + 1) % 4;
          if (m_sub == 3) begin
            m_pix <= (m_pix + 1) % H;
            if (m_pix == H-1) m_line <= (m_line + 1) % V;
          end
        end
      end
    end
  end

  function automatic bit f_win(int p);
    return (p >= VXS) && (p < VXS + 5*VXP);
  endfunction
  function automatic int f_step(int p);
    return (p - VXS) / VXP;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      if (!m_run) begin
        chk("R11", "outputs", int'({hclk_a, hclk_b, rst_gate, samp_ref, samp_dat, vclk,
                                   rdout_a, rdout_b, sweep, line_start}), 0);
        chk("R11", "counters", int'(pix_phase) + int'(pix_cnt) + int'(line_cnt), 0);
      end else begin
        bit w; int s; int ev;
        w = f_win(m_pix); s = f_step(m_pix);
        chk("R1", "pix_phase", int'(pix_phase), m_sub);
        chk("R1", "pix_cnt", int'(pix_cnt), m_pix);
        chk("R1", "line_cnt", int'(line_cnt), m_line);
        chk("R10", "line_start", int'(line_start), int'(m_sub == 0 && m_pix == 0));
        chk("R2 R5", "hclk_a", int'(hclk_a), int'(!w && m_sub >= 2));
        chk("R2 R5", "hclk_b", int'(hclk_b), int'(!(!w && m_sub >= 2)));
        chk("R3 R5", "rst_gate", int'(rst_gate), int'(!w && m_sub == 0));
        chk("R3 R5", "samp_ref", int'(samp_ref), int'(!w && m_sub == 1));
        chk("R3 R5", "samp_dat", int'(samp_dat), int'(!w && m_sub == 3));
        ev = 0;
        for (int i = 0; i < 4; i++) if (w && (s == i || s == i+1)) ev |= (1 << i);
        chk("R4", "vclk", int'(vclk), ev);
        chk("R6", "rdout_a", int'(rdout_a), int'(w && m_line == RL && s == 1));
        chk("R6", "rdout_b", int'(rdout_b), int'(w && m_line == RL && s == 3));
        chk("R7 R8", "sweep", int'(sweep),
            int'(m_line < m_shut && m_pix >= XS && m_pix < XS + XL));
      end
    end
  end

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    // R9: counters restarted at the edge that saw the pulse
    chk("R9", "restart", int'(pix_phase) + int'(pix_cnt) + int'(line_cnt), 0);
  endtask

  localparam int FRAME = H * V * 4;

  initial begin
    void'($urandom(32'd1701));
    rst_n = 1'b0; frame_start = 1'b0; shutter_line = '0;
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(6);
    // directed: shutter at line 4, two frames
    shutter_line = LW'(4);
    pulse_start();
    wait_cycles(2 * FRAME);
    // R8: change mid-frame, must not affect the current frame
    wait_cycles(FRAME / 2);
    shutter_line = LW'(9);
    wait_cycles(FRAME);
    // no sweep at all, then every line
    shutter_line = '0;
    pulse_start();
    wait_cycles(FRAME);
    shutter_line = LW'(15);
    pulse_start();
    wait_cycles(FRAME);
    // R9: restart in mid pixel at sub-phase 2
    while (pix_phase != 2'd2) @(negedge clk);
    pulse_start();
    wait_cycles(100);
    // random mix
    for (int k = 0; k < 30; k++) begin
      wait_cycles(1 + ($urandom % 600));
      shutter_line = LW'($urandom % 16);
      if (($urandom % 3) == 0) pulse_start();
    end
    // reset in the middle of operation
    rst_n = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(FRAME);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule